// File: doc/BRIEF.md
# Block Write-Protection Lock Controller

This block holds a write-protection state for every erase block of a flash array and changes those states on command. Each block is in one of three states: unlocked (writable), locked (protected, can be unlocked again) or lock-tight (protected until reset). A host first loads a first-block and a last-block address register. It then issues one of four commands: unlock a range, lock a range, lock-tight a range, or unlock the whole array.

A command walks its range one block per clock. Each block is either rewritten or skipped, depending on its current state. The state of the last block written is kept in a status register. While the walk runs, `busy` is high. A single-cycle `done` pulse marks the end of the walk, and a sticky interrupt flag is raised at the same time. If the walk reaches an index outside the array, it stops and raises a command error. The host can read back the state of any block through a read port.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After reset every block reads locked and the status register holds the locked code. The state codes are one-hot: 3'b001 means lock-tight, 3'b010 means locked, 3'b100 means unlocked. Also after reset both address registers are 0 and busy, done, cmd_err and int_flag are low.
- R2: A write to the first-block register stores the low ADDR_W bits of `addr_wdata` and also copies that value into the last-block register. A write to the last-block register changes only the last-block register.
- R3: Command 8'h23 sets every block from the first address through the last address, inclusive, to unlocked. Blocks that are lock-tight are skipped.
- R4: Command 8'h2A sets every block in the range to locked. Blocks that are lock-tight are skipped.
- R5: Command 8'h2C sets every block in the range to lock-tight. Blocks that are currently unlocked are skipped.
- R6: Command 8'h27 sets every block of the array to unlocked, except blocks that are lock-tight.
- R7: Each block that a command writes also loads its new state into `wp_status`. A skipped block leaves `wp_status` unchanged.
- R8: The walk handles one block per cycle. `busy` stays high for exactly one cycle per block visited. `done` is high for one cycle, in the cycle after `busy` falls, and is never high together with `busy`.
- R9: When the walk visits an index at or above NUM_BLOCKS, it ends in that cycle and sets `cmd_err`. Blocks visited before that index keep their updates.
- R10: If the first address is greater than the last address, a range command changes no block. It pulses `done` in the cycle after it is issued, and `busy` stays low.
- R11: `int_flag` is set together with every `done` and stays set until `int_clr` is pulsed. `int_clr` clears both `int_flag` and `cmd_err`.
- R12: A command issued while `busy` is high has no effect. A command code outside the four listed has no effect either: no `done`, no `int_flag` and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_we | input | 1 | Write strobe for the first-block register |
| end_we | input | 1 | Write strobe for the last-block register |
| addr_wdata | input | HOST_W | Write data for both address registers |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| int_clr | input | 1 | Clears int_flag and cmd_err |
| rd_idx | input | ADDR_W | Index of the block to read back |
| start_addr | output | ADDR_W | First-block register |
| end_addr | output | ADDR_W | Last-block register |
| rd_state | output | 3 | State of block rd_idx (0 if the index is out of range) |
| wp_status | output | 3 | State of the block written most recently |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| cmd_err | output | 1 | Sticky flag: the walk left the array |
| int_flag | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume that the address registers are not written while a walk runs. They also assume that `int_clr` is not pulsed in the same cycle as the end of a walk, because the set/clear priority then depends on timing. The stimulus issues every register write and every clear only while the block is idle, after the previous `done` has been seen. The one command deliberately driven during a walk targets the R12 ignore path.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

   // one-hot block protection codes
   localparam logic [2:0] WP_TIGHT  = 3'b001;
   localparam logic [2:0] WP_LOCKED = 3'b010;
   localparam logic [2:0] WP_OPEN   = 3'b100;

   localparam logic [7:0] CMD_UNLOCK_RANGE = 8'h23;
   localparam logic [7:0] CMD_UNLOCK_ALL   = 8'h27;
   localparam logic [7:0] CMD_LOCK_RANGE   = 8'h2A;
   localparam logic [7:0] CMD_TIGHT_RANGE  = 8'h2C;

   typedef enum logic [1:0] {
      OP_UNLOCK = 2'd0,
      OP_LOCK   = 2'd1,
      OP_TIGHT  = 2'd2
   } wp_op_e;

   typedef struct packed {
      logic       wr;
      logic [2:0] st;
   } wp_upd_t;

   // next state of one block under an operation, with skip rules
   function automatic wp_upd_t wp_apply(input wp_op_e op, input logic [2:0] cur);
      wp_upd_t u;
      u.wr = 1'b0;
      u.st = cur;
      case (op)
         OP_UNLOCK: if (cur != WP_TIGHT) begin u.wr = 1'b1; u.st = WP_OPEN;   end
         OP_LOCK:   if (cur != WP_TIGHT) begin u.wr = 1'b1; u.st = WP_LOCKED; end
         OP_TIGHT:  if (cur != WP_OPEN)  begin u.wr = 1'b1; u.st = WP_TIGHT;  end
         default:   u.wr = 1'b0;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/wp_addr_regs.sv
module wp_addr_regs #(
   parameter int HOST_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              end_we,
   input  logic [HOST_W-1:0] wdata,
   output logic [ADDR_W-1:0] start_q,
   output logic [ADDR_W-1:0] end_q
);

   logic [ADDR_W-1:0] wval;

   if (HOST_W < ADDR_W) begin : g_bad_width
      $error("wp_addr_regs: HOST_W must cover ADDR_W");
   end

   if (HOST_W > ADDR_W) begin : g_drop_high
      logic unused_hi;
      assign unused_hi = ^wdata[HOST_W-1:ADDR_W];
   end

   assign wval = wdata[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
      end else if (start_we) begin
         start_q <= wval;
         end_q   <= wval;
      end else if (end_we) begin
         end_q   <= wval;
      end
   end

   // R2
   start_copies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_we |=> (end_q == start_q));

   // R2
   end_keeps_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_we && !start_we) |=> $stable(start_q));

endmodule

// File: rtl/wp_walker.sv
module wp_walker
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 12,
   parameter int ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic              int_clr,
   input  logic [ADDR_W-1:0] start_q,
   input  logic [ADDR_W-1:0] end_q,
   output logic              busy,
   output logic              done,
   output logic              cmd_err,
   output logic              int_flag,
   output logic              blk_we,
   output logic [ADDR_W-1:0] blk_idx,
   output wp_op_e            blk_op
);

   localparam logic [ADDR_W-1:0] LAST_BLK = ADDR_W'(NUM_BLOCKS - 1);

   logic [ADDR_W-1:0] cur_q, last_q;
   wp_op_e            op_q, op_d;
   logic              busy_q, done_q, err_q, int_q;
   logic              known, all_blk, in_range;

   always_comb begin
      known   = 1'b1;
      all_blk = 1'b0;
      op_d    = OP_LOCK;
      case (cmd_code)
         CMD_UNLOCK_RANGE: op_d = OP_UNLOCK;
         CMD_UNLOCK_ALL:   begin op_d = OP_UNLOCK; all_blk = 1'b1; end
         CMD_LOCK_RANGE:   op_d = OP_LOCK;
         CMD_TIGHT_RANGE:  op_d = OP_TIGHT;
         default:          known = 1'b0;
      endcase
   end

   assign in_range = (32'(cur_q) < NUM_BLOCKS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
         op_q   <= OP_LOCK;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         int_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (int_clr) begin
            int_q <= 1'b0;
            err_q <= 1'b0;
         end
         if (!busy_q) begin
            if (cmd_valid && known) begin
               op_q <= op_d;
               if (all_blk) begin
                  cur_q  <= '0;
                  last_q <= LAST_BLK;
                  busy_q <= 1'b1;
               end else if (start_q > end_q) begin
                  done_q <= 1'b1;
                  int_q  <= 1'b1;
               end else begin
                  cur_q  <= start_q;
                  last_q <= end_q;
                  busy_q <= 1'b1;
               end
            end
         end else if (!in_range) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            int_q  <= 1'b1;
            err_q  <= 1'b1;
         end else if (cur_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            int_q  <= 1'b1;
         end else begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign cmd_err  = err_q;
   assign int_flag = int_q;
   assign blk_we   = busy_q && in_range;
   assign blk_idx  = cur_q;
   assign blk_op   = op_q;

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R8
   walk_steps_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && rst_n && $past(rst_n)) |-> (blk_idx == $past(blk_idx) + 1'b1));

   // R9
   err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> done);

   // R11
   done_sets_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int_flag);

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 12,
   parameter int ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  wp_op_e            wr_op,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [2:0]        rd_state,
   output logic [2:0]        wp_status
);

   logic [2:0] st_q [NUM_BLOCKS];
   logic [2:0] cur_st;
   wp_upd_t    upd;
   logic [2:0] status_q;

   always_comb begin
      cur_st = WP_LOCKED;
      for (int i = 0; i < NUM_BLOCKS; i++) begin
         if (wr_idx == ADDR_W'(i)) cur_st = st_q[i];
      end
   end

   assign upd = wp_apply(wr_op, cur_st);

   for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[gi] <= WP_LOCKED;
         end else if (wr_en && upd.wr && wr_idx == ADDR_W'(gi)) begin
            st_q[gi] <= upd.st;
         end
      end

      // R1
      blk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(st_q[gi]) == 1);

      // R5
      tight_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[gi] == WP_TIGHT) |=> (st_q[gi] == WP_TIGHT));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= WP_LOCKED;
      end else if (wr_en && upd.wr) begin
         status_q <= upd.st;
      end
   end

   always_comb begin
      rd_state = 3'b000;
      for (int i = 0; i < NUM_BLOCKS; i++) begin
         if (rd_idx == ADDR_W'(i)) rd_state = st_q[i];
      end
   end

   assign wp_status = status_q;

   // R7
   status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wp_status) == 1);

   // R7
   status_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wp_status));

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
   import wp_lock_pkg::*;
#(
   parameter  int NUM_BLOCKS = 12,
   parameter  int HOST_W     = 16,
   localparam int ADDR_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              end_we,
   input  logic [HOST_W-1:0] addr_wdata,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic              int_clr,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] end_addr,
   output logic [2:0]        rd_state,
   output logic [2:0]        wp_status,
   output logic              busy,
   output logic              done,
   output logic              cmd_err,
   output logic              int_flag
);

   if (NUM_BLOCKS < 2) begin : g_bad_count
      $error("wp_lock_ctrl: NUM_BLOCKS must be at least 2");
   end

   logic              blk_we;
   logic [ADDR_W-1:0] blk_idx;
   wp_op_e            blk_op;

   wp_addr_regs #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_we (start_we),
      .end_we   (end_we),
      .wdata    (addr_wdata),
      .start_q  (start_addr),
      .end_q    (end_addr)
   );

   wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .int_clr   (int_clr),
      .start_q   (start_addr),
      .end_q     (end_addr),
      .busy      (busy),
      .done      (done),
      .cmd_err   (cmd_err),
      .int_flag  (int_flag),
      .blk_we    (blk_we),
      .blk_idx   (blk_idx),
      .blk_op    (blk_op)
   );

   wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (blk_we),
      .wr_idx    (blk_idx),
      .wr_op     (blk_op),
      .rd_idx    (rd_idx),
      .rd_state  (rd_state),
      .wp_status (wp_status)
   );

   // R10
   empty_range_quick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_code == CMD_LOCK_RANGE && start_addr > end_addr)
         |=> (done && !busy));

   // R12
   unknown_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_code != CMD_UNLOCK_RANGE && cmd_code != CMD_UNLOCK_ALL &&
       cmd_code != CMD_LOCK_RANGE && cmd_code != CMD_TIGHT_RANGE) |=> (!busy && !done));

endmodule

// File: tb/sim_wp_lock_ctrl.sv
`timescale 1ns/1ps
module sim_wp_lock_ctrl;

   localparam int NB = 12;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_we = 1'b0, end_we = 1'b0, cmd_valid = 1'b0, int_clr = 1'b0;
   logic [15:0]   addr_wdata = '0;
   logic [7:0]    cmd_code = '0;
   logic [AW-1:0] rd_idx = '0;
   logic [AW-1:0] start_addr, end_addr;
   logic [2:0]    rd_state, wp_status;
   logic          busy, done, cmd_err, int_flag;

   always #2 clk = ~clk;

   wp_lock_ctrl #(.NUM_BLOCKS(NB), .HOST_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
      .addr_wdata(addr_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .int_clr(int_clr), .rd_idx(rd_idx), .start_addr(start_addr),
      .end_addr(end_addr), .rd_state(rd_state), .wp_status(wp_status),
      .busy(busy), .done(done), .cmd_err(cmd_err), .int_flag(int_flag)
   );

   typedef struct {
      int         cycles;
      bit         err;
      logic [2:0] status;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [2:0] model [NB];
   logic [2:0] m_status;
   bit         m_err;
   int         m_s, m_e;
   int         checks = 0, fails = 0;
   int         busy_cnt = 0, done_seen = 0;
   bit         finished = 0;

   task automatic chk(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // monitor: pops expected completions as done appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (done) begin
            if (sb.size() == 0) begin
               chk("R12", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(e.tag, "busy cycles (R8)", busy_cnt, e.cycles);
               chk(e.tag, "cmd_err (R9)", cmd_err, e.err);
               chk(e.tag, "wp_status (R7)", wp_status, e.status);
               chk(e.tag, "int_flag (R11)", int_flag, 1);
            end
            busy_cnt = 0;
            done_seen++;
         end
      end
   end

   function automatic void model_apply(input logic [7:0] code, input int i);
      logic [2:0] c;
      c = model[i];
      case (code)
         8'h23, 8'h27: if (c != 3'b001) begin model[i] = 3'b100; m_status = 3'b100; end
         8'h2A:        if (c != 3'b001) begin model[i] = 3'b010; m_status = 3'b010; end
         8'h2C:        if (c != 3'b100) begin model[i] = 3'b001; m_status = 3'b001; end
         default: ;
      endcase
   endfunction

   function automatic int model_run(input logic [7:0] code);
      int s, e, cyc;
      cyc = 0;
      s = (code == 8'h27) ? 0 : m_s;
      e = (code == 8'h27) ? NB - 1 : m_e;
      for (int i = s; i <= e; i++) begin
         cyc++;
         if (i >= NB) begin m_err = 1; break; end
         model_apply(code, i);
      end
      return cyc;
   endfunction

   task automatic pulse_cmd(input logic [7:0] code);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_code = code;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic run_cmd(input logic [7:0] code, input string tag);
      exp_t e;
      int   d0;
      e.cycles = model_run(code);
      e.err    = m_err;
      e.status = m_status;
      e.tag    = tag;
      sb.push_back(e);
      d0 = done_seen;
      pulse_cmd(code);
      wait (done_seen > d0);
      @(posedge clk); #1;
   endtask

   task automatic check_blocks(input string tag);
      for (int i = 0; i < NB; i++) begin
         rd_idx = AW'(i);
         #0.1;
         chk(tag, $sformatf("block %0d state", i), rd_state, model[i]);
      end
   endtask

   task automatic wr_start(input logic [15:0] v);
      @(posedge clk); #1;
      start_we = 1'b1; addr_wdata = v;
      @(posedge clk); #1;
      start_we = 1'b0;
      m_s = int'(v[AW-1:0]);
      m_e = m_s;
   endtask

   task automatic wr_end(input logic [15:0] v);
      @(posedge clk); #1;
      end_we = 1'b1; addr_wdata = v;
      @(posedge clk); #1;
      end_we = 1'b0;
      m_e = int'(v[AW-1:0]);
   endtask

   initial begin
      #(4 * 150000);
      chk("WATCHDOG", "run completed", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < NB; i++) model[i] = 3'b010;
      m_status = 3'b010; m_err = 0; m_s = 0; m_e = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      check_blocks("R1");
      chk("R1", "wp_status", wp_status, 3'b010);
      chk("R1", "start_addr", start_addr, 0);
      chk("R1", "end_addr", end_addr, 0);
      chk("R1", "busy/done/err/int", {busy, done, cmd_err, int_flag}, 0);

      // R2 masking and copy into the end register
      wr_start(16'h0012);
      chk("R2", "start masked", start_addr, 2);
      chk("R2", "end copied", end_addr, 2);
      wr_end(16'h0005);
      chk("R2", "end written", end_addr, 5);
      chk("R2", "start kept", start_addr, 2);

      // R3 unlock 2..5
      run_cmd(8'h23, "R3");
      check_blocks("R3");

      // R5 tight 4..7: 4,5 unlocked are skipped
      wr_start(16'd4); wr_end(16'd7);
      run_cmd(8'h2C, "R5");
      check_blocks("R5");

      // R4 lock 3..6: 6 tight is skipped
      wr_start(16'd3); wr_end(16'd6);
      run_cmd(8'h2A, "R4");
      check_blocks("R4");

      // R7 unlock 6..7: both tight, status unchanged
      wr_start(16'd6); wr_end(16'd7);
      run_cmd(8'h23, "R7");
      check_blocks("R7");
      chk("R7", "status held", wp_status, 3'b010);

      // R6 unlock all
      run_cmd(8'h27, "R6");
      check_blocks("R6");

      // R9 lock 10..14 leaves the array at 12
      wr_start(16'd10); wr_end(16'd14);
      run_cmd(8'h2A, "R9");
      check_blocks("R9");
      chk("R9", "cmd_err after walk", cmd_err, 1);

      // R11 clear
      @(posedge clk); #1 int_clr = 1'b1;
      @(posedge clk); #1 int_clr = 1'b0;
      m_err = 0;
      chk("R11", "int_flag cleared", int_flag, 0);
      chk("R11", "cmd_err cleared", cmd_err, 0);

      // R12 unknown code
      pulse_cmd(8'h55);
      repeat (10) @(posedge clk);
      #1;
      chk("R12", "int_flag after unknown code", int_flag, 0);
      chk("R12", "busy after unknown code", busy, 0);
      check_blocks("R12");

      // R10 empty range
      wr_start(16'd9); wr_end(16'd3);
      run_cmd(8'h2A, "R10");
      check_blocks("R10");

      // R12 command during a walk is ignored
      wr_start(16'd0); wr_end(16'd11);
      begin
         exp_t e;
         int   d0;
         e.cycles = model_run(8'h2A);
         e.err = m_err; e.status = m_status; e.tag = "R12";
         sb.push_back(e);
         d0 = done_seen;
         pulse_cmd(8'h2A);
         pulse_cmd(8'h27);
         chk("R12", "busy during walk", busy, 1);
         wait (done_seen > d0);
      end
      repeat (20) @(posedge clk);
      #1;
      chk("R12", "busy after ignored command", busy, 0);
      check_blocks("R12");

      finish_run();
   end

endmodule